// File: doc/BRIEF.md
# Multi-master I2C bus-free guard

This block sits beside an I2C master engine that shares its SCL and SDA wires with other masters. It brings both raw line levels into the clock domain through a two-stage synchronizer and then through a programmable spike filter. From the cleaned levels it recognises START and STOP conditions and tracks whether the bus is in use. After every STOP it holds the bus busy for a programmed number of clock cycles, so a waiting master cannot fire its START at the moment the previous owner releases SDA. There is one count for standard mode and one for fast mode.

While the local master is transmitting, the block compares the level the master meant to put on SDA with the filtered level at each rising SCL edge. A mismatch is reported as lost arbitration. This status is kept apart from a failed acknowledge, so the engine releases both lines and drives no STOP. The engine passes in its acknowledge sample as a single-cycle strobe. All pins are plain level or pulse signals. There is no data stream and no handshake.

Top module: `mm_busfree_guard`

## Requirements
- R1: After reset, the filtered SCL and SDA are 1, bus_busy is 0, start_ok is 1, status_valid is 0, status_code is 0 and release_bus is 0.
- R2: Each raw line passes through a two-flop synchronizer. A new level reaches the filtered output only after the synchronized input has differed from the filtered output on `filt_width` consecutive filter ticks. A width of 0 acts as 1. A return to the current level clears the count, so shorter pulses are removed.
- R3: With `prescale_en` at 0, a filter tick happens every clock cycle. With `prescale_en` at 1, a tick happens once every 32 cycles, taken from a counter that runs freely from reset. One width unit is then 32 cycles.
- R4: `start_det` pulses for one cycle when filtered SDA goes from 1 to 0 while filtered SCL was 1 in both the previous cycle and this one. `stop_det` pulses in the same way when SDA goes from 0 to 1.
- R5: `bus_busy` is 1 from the cycle after any START or STOP detection.
- R6: A STOP loads a countdown of N cycles. N is `free_cnt_fast` when `fast_mode` is 1 and `free_cnt_std` otherwise, sampled at the STOP. `bus_busy` then stays 1 for N cycles after the STOP edge (at least one). `start_ok` is the inverse of `bus_busy`.
- R7: A START that is detected during the countdown cancels it. `bus_busy` stays 1 until a later STOP plus its full countdown.
- R8: When `tx_active` is 1, `sda_intent` is 1 and the filtered SDA is 0 on a rising filtered SCL, the next cycle shows `status_valid` at 1 with `status_code` 1 (arbitration lost).
- R9: Lost arbitration sets `release_bus`. It stays 1 until `bus_busy` has been 0 on a clock edge. While it is 1, no status is reported.
- R10: An `ack_valid` cycle with `ack_nack` at 1 gives `status_valid` with `status_code` 2 (no acknowledge) on the next cycle. Arbitration loss takes priority in the same cycle. `status_code` is 0 whenever `status_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| prescale_en | input | 1 | Filter tick every 32 cycles when 1 |
| filt_width | input | FW (6) | Spike filter width in ticks |
| fast_mode | input | 1 | Selects the fast-mode bus-free count |
| free_cnt_std | input | CW (16) | Bus-free cycles, standard mode |
| free_cnt_fast | input | CW (16) | Bus-free cycles, fast mode |
| tx_active | input | 1 | Local master is driving address or data bits |
| sda_intent | input | 1 | Level the local master wants on SDA |
| ack_valid | input | 1 | Strobe: acknowledge slot sampled |
| ack_nack | input | 1 | Sampled acknowledge was high (not acknowledged) |
| scl_f | output | 1 | Filtered SCL |
| sda_f | output | 1 | Filtered SDA |
| start_det | output | 1 | START seen this cycle |
| stop_det | output | 1 | STOP seen this cycle |
| bus_busy | output | 1 | Bus owned or inside the bus-free gap |
| start_ok | output | 1 | Local master may issue a START |
| status_valid | output | 1 | Status pulse |
| status_code | output | 2 | 0 none, 1 arbitration lost, 2 no acknowledge |
| release_bus | output | 1 | Master must float SCL and SDA and send no STOP |

## Verification
The assertions assume that `filt_width`, `prescale_en` and both free counts stay constant while a countdown or a filter count is running. They also assume that `ack_valid` is only raised while the engine is actively transferring. The bench changes configuration only while both lines have been idle high for longer than the gap. It drives the lines in steps held well beyond the filter width, except where a pulse is meant to be too short. A behavioural model of the synchronizer, the filter, the detection and the countdown is compared against every output on every cycle.

// File: rtl/mbg_pkg.sv
package mbg_pkg;
  typedef enum logic [1:0] {
    ST_NONE = 2'd0,
    ST_ARB  = 2'd1,
    ST_NACK = 2'd2
  } stat_e;
endpackage

// File: rtl/mbg_glitch_filter.sv
module mbg_glitch_filter #(
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw_in,
  input  logic          tick,
  input  logic [FW-1:0] width,
  output logic          level
);
  logic          sync1, sync2;
  logic [FW-1:0] cnt;
  logic [FW:0]   eff;
  logic [FW:0]   nxt;

  assign eff = (width == '0) ? (FW+1)'(1) : {1'b0, width};
  assign nxt = {1'b0, cnt} + (FW+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= raw_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b1;
      cnt   <= '0;
    end else if (sync2 == level) begin
      cnt <= '0;
    end else if (tick) begin
      if (nxt >= eff) begin
        level <= sync2;
        cnt   <= '0;
      end else begin
        cnt <= nxt[FW-1:0];
      end
    end
  end

  // R2: the filtered level only moves toward the synchronized input
  a_r2_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> level == $past(sync2));
endmodule

// File: rtl/mbg_cond_detect.sv
module mbg_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start_det = scl & scl_q &  sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q &  sda;
  assign scl_rise  = scl & ~scl_q;

  // R4: conditions only while the clock line is high
  a_r4_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |-> scl);
endmodule

// File: rtl/mbg_free_timer.sv
module mbg_free_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          fast_mode,
  input  logic [CW-1:0] cnt_std,
  input  logic [CW-1:0] cnt_fast,
  output logic          busy
);
  logic          counting;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      counting <= 1'b0;
      cnt      <= '0;
    end else if (start_det) begin
      busy     <= 1'b1;
      counting <= 1'b0;
    end else if (stop_det) begin
      busy     <= 1'b1;
      counting <= 1'b1;
      cnt      <= fast_mode ? cnt_fast : cnt_std;
    end else if (counting) begin
      if (cnt <= CW'(1)) begin
        busy     <= 1'b0;
        counting <= 1'b0;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy);
  a_r5_stop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> busy);
  a_r7_start_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !counting);
  a_r6_free_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(counting));
endmodule

// File: rtl/mbg_arb_status.sv
module mbg_arb_status
  import mbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       sda,
  input  logic       tx_active,
  input  logic       sda_intent,
  input  logic       ack_valid,
  input  logic       ack_nack,
  input  logic       busy,
  output logic       status_valid,
  output logic [1:0] status_code,
  output logic       release_bus
);
  logic  arb_hit, nack_hit;
  stat_e code_d;

  assign arb_hit  = scl_rise & tx_active & sda_intent & ~sda & ~release_bus;
  assign nack_hit = ack_valid & ack_nack & ~release_bus;

  always_comb begin
    if (arb_hit)       code_d = ST_ARB;
    else if (nack_hit) code_d = ST_NACK;
    else               code_d = ST_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_valid <= 1'b0;
      status_code  <= ST_NONE;
      release_bus  <= 1'b0;
    end else begin
      status_valid <= arb_hit | nack_hit;
      status_code  <= code_d;
      if (arb_hit)    release_bus <= 1'b1;
      else if (!busy) release_bus <= 1'b0;
    end
  end

  a_r10_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> (status_code == ST_ARB || status_code == ST_NACK));
  a_r8_release_with_arb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(release_bus) |-> (status_valid && status_code == ST_ARB));
  a_r9_quiet_released: assert property (@(posedge clk) disable iff (!rst_n)
    (release_bus && $past(release_bus)) |-> !status_valid);
endmodule

// File: rtl/mm_busfree_guard.sv
module mm_busfree_guard #(
  parameter int FW       = 6,
  parameter int CW       = 16,
  parameter int PRE_LOG  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          prescale_en,
  input  logic [FW-1:0] filt_width,
  input  logic          fast_mode,
  input  logic [CW-1:0] free_cnt_std,
  input  logic [CW-1:0] free_cnt_fast,
  input  logic          tx_active,
  input  logic          sda_intent,
  input  logic          ack_valid,
  input  logic          ack_nack,
  output logic          scl_f,
  output logic          sda_f,
  output logic          start_det,
  output logic          stop_det,
  output logic          bus_busy,
  output logic          start_ok,
  output logic          status_valid,
  output logic [1:0]    status_code,
  output logic          release_bus
);
  localparam int NLINES = 2;

  logic [PRE_LOG-1:0] pre_cnt;
  logic               pre_tick;
  logic [NLINES-1:0]  raw_v, filt_v;
  logic               scl_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + PRE_LOG'(1);
  end
  assign pre_tick = ~prescale_en | (&pre_cnt);

  // R3: prescaled ticks never arrive on consecutive cycles
  a_r3_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    (prescale_en && pre_tick) |=> !(prescale_en && pre_tick));

  assign raw_v = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    mbg_glitch_filter #(.FW(FW)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_in(raw_v[g]),
      .tick  (pre_tick),
      .width (filt_width),
      .level (filt_v[g])
    );
  end

  assign scl_f = filt_v[0];
  assign sda_f = filt_v[1];

  mbg_cond_detect u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl_f),
    .sda      (sda_f),
    .start_det(start_det),
    .stop_det (stop_det),
    .scl_rise (scl_rise)
  );

  mbg_free_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_det(start_det),
    .stop_det (stop_det),
    .fast_mode(fast_mode),
    .cnt_std  (free_cnt_std),
    .cnt_fast (free_cnt_fast),
    .busy     (bus_busy)
  );

  assign start_ok = ~bus_busy;

  mbg_arb_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_rise    (scl_rise),
    .sda         (sda_f),
    .tx_active   (tx_active),
    .sda_intent  (sda_intent),
    .ack_valid   (ack_valid),
    .ack_nack    (ack_nack),
    .busy        (bus_busy),
    .status_valid(status_valid),
    .status_code (status_code),
    .release_bus (release_bus)
  );
endmodule

// File: tb/mm_busfree_guard_tb_top.sv
module mm_busfree_guard_tb_top;
  localparam int CLK_P = 10;
  localparam int FW = 6;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic prescale_en = 1'b0;
  logic [FW-1:0] filt_width = 6'd3;
  logic fast_mode = 1'b0;
  logic [CW-1:0] free_cnt_std = 16'd20, free_cnt_fast = 16'd8;
  logic tx_active = 1'b0, sda_intent = 1'b1, ack_valid = 1'b0, ack_nack = 1'b0;
  logic scl_f, sda_f, start_det, stop_det, bus_busy, start_ok;
  logic status_valid, release_bus;
  logic [1:0] status_code;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  mm_busfree_guard #(.FW(FW), .CW(CW), .PRE_LOG(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .prescale_en(prescale_en), .filt_width(filt_width), .fast_mode(fast_mode),
    .free_cnt_std(free_cnt_std), .free_cnt_fast(free_cnt_fast),
    .tx_active(tx_active), .sda_intent(sda_intent), .ack_valid(ack_valid),
    .ack_nack(ack_nack), .scl_f(scl_f), .sda_f(sda_f), .start_det(start_det),
    .stop_det(stop_det), .bus_busy(bus_busy), .start_ok(start_ok),
    .status_valid(status_valid), .status_code(status_code), .release_bus(release_bus)
  );

  // behavioural reference: index 0 = SCL, 1 = SDA
  int ms1[2], ms2[2], mf[2], mc[2];
  int mpc, mq_scl, mq_sda, mbusy, mcnting, mcnt, msv, mcode, mrel;

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin ms1[i] = 1; ms2[i] = 1; mf[i] = 1; mc[i] = 0; end
    mpc = 0; mq_scl = 1; mq_sda = 1; mbusy = 0; mcnting = 0; mcnt = 0;
    msv = 0; mcode = 0; mrel = 0;
  endtask

  function automatic int m_start(); return (mf[0] && mq_scl && mq_sda && !mf[1]) ? 1 : 0; endfunction
  function automatic int m_stop();  return (mf[0] && mq_scl && !mq_sda && mf[1]) ? 1 : 0; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int st, sp, rise, tk, arb, nk, eff, rin[2];
      st = m_start(); sp = m_stop(); rise = (mf[0] && !mq_scl) ? 1 : 0;
      tk = (!prescale_en || mpc == 31) ? 1 : 0;
      mpc = (mpc + 1) % 32;
      arb = (rise && tx_active && sda_intent && !mf[1] && !mrel) ? 1 : 0;
      nk  = (ack_valid && ack_nack && !mrel) ? 1 : 0;
      msv = (arb || nk) ? 1 : 0;
      mcode = arb ? 1 : (nk ? 2 : 0);
      if (arb) mrel = 1; else if (!mbusy) mrel = 0;
      if (st) begin mbusy = 1; mcnting = 0; end
      else if (sp) begin mbusy = 1; mcnting = 1; mcnt = fast_mode ? int'(free_cnt_fast) : int'(free_cnt_std); end
      else if (mcnting) begin
        if (mcnt <= 1) begin mbusy = 0; mcnting = 0; end else mcnt--;
      end
      mq_scl = mf[0]; mq_sda = mf[1];
      eff = (filt_width == 0) ? 1 : int'(filt_width);
      for (int i = 0; i < 2; i++) begin
        if (ms2[i] == mf[i]) mc[i] = 0;
        else if (tk) begin
          if (mc[i] + 1 >= eff) begin mf[i] = ms2[i]; mc[i] = 0; end else mc[i]++;
        end
      end
      rin[0] = scl_in; rin[1] = sda_in;
      for (int i = 0; i < 2; i++) begin ms2[i] = ms1[i]; ms1[i] = rin[i]; end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "scl_f", scl_f, mf[0]);
      chk("R2", "sda_f", sda_f, mf[1]);
      chk("R4", "start_det", start_det, m_start());
      chk("R4", "stop_det", stop_det, m_stop());
      chk("R6", "bus_busy", bus_busy, mbusy);
      chk("R6", "start_ok", start_ok, !mbusy);
      chk("R10", "status_valid", status_valid, msv);
      chk("R8", "status_code", status_code, mcode);
      chk("R9", "release_bus", release_bus, mrel);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic lines(logic c, logic d, int n);
    scl_in = c; sda_in = d; wait_cyc(n);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R1 reset state
    chk("R1", "reset scl_f", scl_f, 1);
    chk("R1", "reset sda_f", sda_f, 1);
    chk("R1", "reset busy", bus_busy, 0);
    chk("R1", "reset start_ok", start_ok, 1);
    chk("R1", "reset status", {status_valid, status_code, release_bus}, 0);
    lines(1, 1, 6);
    // R2 short glitch on SDA removed (2 cycles < width 3)
    lines(1, 0, 2); lines(1, 1, 10);
    chk("R2", "glitch ignored busy", bus_busy, 0);
    // normal transfer, standard mode
    lines(1, 0, 10);
    chk("R5", "busy after START", bus_busy, 1);
    tx_active = 1; sda_intent = 1;
    lines(0, 1, 6); lines(1, 1, 8); lines(0, 1, 6);
    sda_intent = 0;
    lines(0, 0, 6); lines(1, 0, 8); lines(0, 0, 6);
    tx_active = 0;
    ack_valid = 1; ack_nack = 0; wait_cyc(1); ack_valid = 0;
    lines(0, 0, 6); lines(1, 0, 8); lines(1, 1, 40);
    chk("R6", "free after std gap", start_ok, 1);
    // fast mode gap
    fast_mode = 1;
    lines(1, 0, 10); lines(0, 0, 6); lines(1, 0, 8); lines(1, 1, 20);
    // R7: START inside the gap cancels the countdown
    fast_mode = 0;
    lines(1, 0, 10); lines(0, 0, 6); lines(1, 0, 8); lines(1, 1, 8);
    lines(1, 0, 40);
    chk("R7", "busy held after cancel", bus_busy, 1);
    // R10 no acknowledge
    lines(0, 0, 6);
    ack_valid = 1; ack_nack = 1; wait_cyc(1); ack_valid = 0; ack_nack = 0;
    wait_cyc(3);
    // R8 arbitration loss, with a held NACK to show priority
    tx_active = 1; sda_intent = 1;
    ack_valid = 1; ack_nack = 1;
    lines(1, 0, 8);
    ack_valid = 0; ack_nack = 0;
    lines(0, 0, 4);
    tx_active = 0;
    chk("R9", "release held", release_bus, 1);
    ack_valid = 1; ack_nack = 1; wait_cyc(1); ack_valid = 0; ack_nack = 0;
    wait_cyc(3);
    chk("R9", "no status while released", status_valid, 0);
    lines(1, 0, 8); lines(1, 1, 40);
    chk("R9", "release cleared", release_bus, 0);
    // R3 prescaler: width 2 ticks of 32 cycles
    prescale_en = 1; filt_width = 6'd2;
    wait_cyc(40);
    lines(1, 0, 20); lines(1, 1, 80);
    chk("R3", "short pulse filtered", bus_busy, 0);
    lines(1, 0, 120);
    chk("R3", "long pulse passes", sda_f, 0);
    lines(1, 1, 140);
    // width 0 acts as 1
    prescale_en = 0; filt_width = 6'd0;
    lines(1, 1, 40);
    lines(1, 0, 8); lines(1, 1, 40);
    chk("R6", "gap done width0", start_ok, 1);
    finish_run();
  end
endmodule